// File: doc/BRIEF.md
# Status-code I2C master controller

This block is a byte-at-a-time I2C bus master attached to a simple register port. Software loads a byte into the data register and sets bits in the control register. The controller then performs one bus event: a START, a repeated START, one transmitted byte with its acknowledge bit, one received byte with a chosen acknowledge bit, or a STOP. Each event except STOP ends by setting a sticky flag and posting an 8-bit status code. The controller then holds SCL low and does nothing more until software clears the flag with a control write.

SCL and SDA are open-drain: the block drives an enable that pulls a line low, and reads SDA back through a two-stage synchronizer. Each SCL bit period has ten sub-phases. The sub-phase length comes from a baud register, so the bit period is 10*(M+1)*2^(N+1) core clocks. A write to the soft-reset location puts the whole block back in its power-up state.

Top module: `i2c_status_master`

## Requirements
- R1: Register byte offsets are 0x00 own slave address, 0x04 data, 0x08 control, 0x0C (read: status code, write: baud), 0x10 extended slave address and 0x1C soft reset. Unmapped reads return 0. After reset the status reads 0xF8, and control, data and both slave-address registers read 0.
- R2: The control bits are [2] ACK enable, [3] event flag, [4] STOP request, [5] START request, [6] enable and [7] interrupt enable. Writing 0 to bit 3 clears the flag. Writing 1 to bit 3 never sets it.
- R3: `irq` is high exactly when the event flag and the interrupt enable are both set.
- R4: A START request while the bus is idle gives a START condition: SDA falls while SCL is high. The flag is then set with status 0x08.
- R5: A START request after the flag is cleared in the middle of a transaction gives a repeated START with status 0x10.
- R6: The first byte sent after a START or repeated START goes out MSB first, and its bit 0 selects read (1) or write (0). The status is then 0x18 for write acked, 0x20 for write not acked, 0x40 for read acked or 0x48 for read not acked.
- R7: Each later transmitted byte posts 0x28 if the slave acked it or 0x30 if not.
- R8: After status 0x40 or 0x50, clearing the flag receives one byte. The controller drives ACK if control bit 2 was set and NAK if not, and posts 0x50 or 0x58 to match. The received byte is then readable at the data register.
- R9: While the flag is set, SCL is held low and the status code does not change.
- R10: A STOP request ends in a STOP condition (SDA rises while SCL is high). The status returns to 0xF8 and the flag is not set.
- R11: The SCL period is 10*(M+1)*2^(N+1) clocks, with M in baud bits 6:3 and N in bits 2:0. The baud value after reset is 0x44.
- R12: A write to the soft-reset location returns the block to idle and releases both lines. It also restores the status, control, baud and slave-address registers to their reset values.
- R13: Outside START and STOP, SDA changes only while SCL is held low.
- R14: While the enable bit is clear, a pending START request does not start. It starts once the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A wrong phase counter or prescaler shows on the next SCL rising edge as a period that departs from the formula. The bench measures that period over a sweep of small M and N values, with the expected value computed arithmetically. A wrong state decision shows at the event flag and status register: a missing or extra flag, or a wrong code, appears within one byte time after the flag is cleared. A behavioural slave on the bench side records every byte, every START and every STOP. A bit-order error, an SDA edge while SCL is high, or a wrong acknowledge therefore shows as a mismatch in that record before the next event completes.

// File: rtl/i2c_status_master.sv
`timescale 1ns/1ps
module i2c_status_master #(
  parameter int DIVW = 13,
  parameter logic [7:0] BAUD_RST = 8'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam logic [4:0] A_SLA = 5'h00, A_DAT = 5'h04, A_CTL = 5'h08,
                         A_STB = 5'h0C, A_XSL = 5'h10, A_RST = 5'h1C;
  localparam logic [7:0] C_START = 8'h08, C_RSTART = 8'h10, C_AW_ACK = 8'h18,
                         C_AW_NAK = 8'h20, C_DW_ACK = 8'h28, C_DW_NAK = 8'h30,
                         C_AR_ACK = 8'h40, C_AR_NAK = 8'h48, C_DR_ACK = 8'h50,
                         C_DR_NAK = 8'h58, C_IDLE = 8'hF8;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_BIT, S_STOP} st_t;
  st_t st;

  logic [7:0] sla, xsla, dat, code, baud, txb, rxb;
  logic ack_en, iflg, en, inten, start_req, stop_req;
  logic rep, rx, aphase, ackd, ackq, hold;
  logic [3:0] ph, bcnt;
  logic [DIVW-1:0] pcnt, lim;
  logic [1:0] sync;
  logic scl_n, sda_n, bit_v;

  wire srst   = bus_wr && bus_addr == A_RST;
  wire wr_ctl = bus_wr && bus_addr == A_CTL;
  wire sda_s  = sync[1];
  wire busy   = st == S_START || st == S_BIT || st == S_STOP;

  assign lim = (DIVW'(baud[6:3]) + DIVW'(1)) << (4'(baud[2:0]) + 4'd1);
  wire tick   = busy && pcnt == lim - DIVW'(1);
  wire lastph = tick && ph == 4'd9;

  wire released = en && st == S_WAIT && !iflg;
  wire go_stop  = released && stop_req;
  wire go_start = en && start_req && (st == S_IDLE || (released && !stop_req));
  wire go_byte  = released && !stop_req && !start_req;

  assign irq = iflg & inten;

  always_comb begin
    case (bus_addr)
      A_SLA:   bus_rdata = sla;
      A_DAT:   bus_rdata = dat;
      A_CTL:   bus_rdata = {inten, en, start_req, stop_req, iflg, ack_en, 2'b00};
      A_STB:   bus_rdata = code;
      A_XSL:   bus_rdata = xsla;
      default: bus_rdata = 8'h00;
    endcase
  end

  always_comb begin
    if (rx) bit_v = (bcnt == 4'd8) ? ackq : 1'b0;
    else    bit_v = (bcnt == 4'd8) ? 1'b0 : ~txb[3'd7 - bcnt[2:0]];
  end

  always_comb begin
    case (st)
      S_WAIT:  begin scl_n = 1'b1;          sda_n = hold; end
      S_START: begin scl_n = ph < 4'd3;     sda_n = ph >= 4'd7; end
      S_STOP:  begin scl_n = ph < 4'd4;     sda_n = ph < 4'd7; end
      S_BIT:   begin scl_n = ph < 4'd5;     sda_n = (ph == 4'd0) ? hold : bit_v; end
      default: begin scl_n = 1'b0;          sda_n = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st <= S_IDLE;
      sla <= 8'h00; xsla <= 8'h00; dat <= 8'h00; code <= C_IDLE; baud <= BAUD_RST;
      txb <= 8'h00; rxb <= 8'h00;
      ack_en <= 1'b0; iflg <= 1'b0; en <= 1'b0; inten <= 1'b0;
      start_req <= 1'b0; stop_req <= 1'b0;
      rep <= 1'b0; rx <= 1'b0; aphase <= 1'b0; ackd <= 1'b0; ackq <= 1'b0; hold <= 1'b0;
      ph <= 4'd0; bcnt <= 4'd0; pcnt <= '0; sync <= 2'b11;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      sync   <= {sync[0], sda_in};
      scl_oe <= scl_n;
      sda_oe <= sda_n;

      if (bus_wr && bus_addr == A_SLA) sla  <= bus_wdata;
      if (bus_wr && bus_addr == A_XSL) xsla <= bus_wdata;
      if (bus_wr && bus_addr == A_DAT) dat  <= bus_wdata;
      if (bus_wr && bus_addr == A_STB) baud <= bus_wdata;
      if (wr_ctl) begin
        ack_en <= bus_wdata[2];
        en     <= bus_wdata[6];
        inten  <= bus_wdata[7];
        if (bus_wdata[5]) start_req <= 1'b1;
        if (bus_wdata[4]) stop_req  <= 1'b1;
        if (!bus_wdata[3]) iflg <= 1'b0;
      end

      if (!busy || tick) pcnt <= '0;
      else               pcnt <= pcnt + DIVW'(1);
      if (tick) ph <= (ph == 4'd9) ? 4'd0 : ph + 4'd1;

      case (st)
        S_IDLE: begin
          if (stop_req) stop_req <= 1'b0;
          if (go_start) begin
            st <= S_START; start_req <= 1'b0; rep <= 1'b0;
          end
        end
        S_WAIT: begin
          if (go_stop) begin
            st <= S_STOP; stop_req <= 1'b0;
          end else if (go_start) begin
            st <= S_START; start_req <= 1'b0; rep <= 1'b1;
          end else if (go_byte) begin
            st     <= S_BIT;
            bcnt   <= 4'd0;
            rx     <= code == C_AR_ACK || code == C_DR_ACK;
            aphase <= code == C_START || code == C_RSTART;
            txb    <= dat;
            ackq   <= ack_en;
          end
        end
        S_START: begin
          if (lastph) begin
            code <= rep ? C_RSTART : C_START;
            iflg <= 1'b1; hold <= 1'b1; st <= S_WAIT;
          end
        end
        S_BIT: begin
          if (tick && ph == 4'd7) begin
            if (bcnt < 4'd8) rxb <= {rxb[6:0], sda_s};
            else             ackd <= !sda_s;
          end
          if (lastph) begin
            if (bcnt == 4'd8) begin
              iflg <= 1'b1; st <= S_WAIT;
              if (rx) begin
                code <= ackq ? C_DR_ACK : C_DR_NAK;
                dat  <= rxb;
                hold <= ackq;
              end else begin
                hold <= 1'b0;
                if (aphase) code <= ackd ? (txb[0] ? C_AR_ACK : C_AW_ACK)
                                         : (txb[0] ? C_AR_NAK : C_AW_NAK);
                else        code <= ackd ? C_DW_ACK : C_DW_NAK;
              end
            end else begin
              bcnt <= bcnt + 4'd1;
              hold <= bit_v;
            end
          end
        end
        S_STOP: begin
          if (lastph) begin
            code <= C_IDLE; st <= S_IDLE; hold <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: idle state always reports the idle code
  a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> code == C_IDLE);

  // R2: the flag only rises as the end of a hardware bus event
  a_r2_flag_by_hw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflg) |-> ($past(st) == S_START || $past(st) == S_BIT));

  // R9: while the flag is held, SCL stays low and the code is frozen
  a_r9_hold_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && $past(iflg)) |-> scl_oe);
  a_r9_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && $past(iflg)) |-> $stable(code));

  // R10: a STOP never raises the flag
  a_r10_stop_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_STOP |=> !iflg);

  // R13: SDA only moves under a low SCL outside START and STOP
  a_r13_sda_under_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_oe) && !scl_oe && !$past(srst)
     && $past(st) != S_START && $past(st) != S_STOP
     && $past(st, 2) != S_START && $past(st, 2) != S_STOP) |-> $stable(sda_oe));
endmodule

// File: tb/i2c_status_master_tb.sv
`timescale 1ns/1ps
module i2c_status_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = 5'h0;
  logic [7:0] bus_wdata = 8'h0, bus_rdata;
  logic irq, scl_oe, sda_oe, sda_in;
  logic slv_drv = 1'b0;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_drv);
  assign sda_in = sda_line;

  i2c_status_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in));

  int checks = 0, fails = 0;
  int cyc = 0, last_rise = 0, rise_period = 0;
  int n_start = 0, n_stop = 0, nlog = 0, cnt = 0;
  logic ps = 1'b1, pd = 1'b1, first = 1'b0, rd_mode = 1'b0, pend_rd = 1'b0, mack = 1'b0;
  logic nack_data = 1'b0;
  logic [7:0] sh = 8'h0, last_addr = 8'h0, tx_byte = 8'hA5;
  logic [7:0] rx_log [0:15];
  logic [7:0] cb = 8'hC0;
  localparam logic [6:0] SLV = 7'h50;

  always @(posedge clk) cyc++;

  // behavioural slave and bus monitor
  always @(posedge clk) begin
    if (ps && scl_line && pd && !sda_line) begin
      n_start++; cnt = 0; first = 1'b1; rd_mode = 1'b0; slv_drv = 1'b0;
    end else if (ps && scl_line && !pd && sda_line) begin
      n_stop++; rd_mode = 1'b0; slv_drv = 1'b0;
    end else if (!ps && scl_line) begin
      rise_period = cyc - last_rise; last_rise = cyc;
      if (cnt < 8) sh = {sh[6:0], sda_line}; else mack = !sda_line;
      cnt++;
    end else if (ps && !scl_line) begin
      if (cnt == 8) begin
        if (first) begin
          slv_drv = sh[7:1] == SLV; pend_rd = (sh[7:1] == SLV) && sh[0]; last_addr = sh;
        end else if (!rd_mode) begin
          if (nlog < 16) rx_log[nlog] = sh;
          nlog++; slv_drv = !nack_data;
        end else slv_drv = 1'b0;
      end else if (cnt == 9) begin
        cnt = 0;
        if (first) begin first = 1'b0; rd_mode = pend_rd; end
        else if (rd_mode) begin
          if (mack) tx_byte = tx_byte + 8'h11; else rd_mode = 1'b0;
        end
        slv_drv = rd_mode && !tx_byte[7];
      end else if (cnt >= 1 && cnt <= 7 && rd_mode) begin
        slv_drv = !tx_byte[3'(7 - cnt)];
      end
    end
    ps = scl_line; pd = sda_line;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_flag(input string tag);
    logic [7:0] v;
    for (int n = 0; n < 40000; n++) begin
      rd(5'h08, v);
      if (v[3]) return;
    end
    chk({tag, " flag timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] v;
    for (int n = 0; n < 40000; n++) begin
      rd(5'h0C, v);
      if (v == 8'hF8) return;
    end
    chk({tag, " idle timeout"}, 0, 1);
  endtask

  task automatic do_start(input logic [7:0] exp, input string tag);
    logic [7:0] v;
    wr(5'h08, cb | 8'h20); wait_flag(tag);
    rd(5'h0C, v); chk({tag, " start code"}, v, exp);
  endtask

  task automatic do_send(input logic [7:0] b, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    wr(5'h04, b); wr(5'h08, cb); wait_flag(tag);
    rd(5'h0C, v); chk({tag, " send code"}, v, exp);
  endtask

  task automatic do_recv(input logic ack, input logic [7:0] expd, input logic [7:0] expc,
                         input string tag);
    logic [7:0] v;
    wr(5'h08, cb | (ack ? 8'h04 : 8'h00)); wait_flag(tag);
    rd(5'h0C, v); chk({tag, " recv code"}, v, expc);
    rd(5'h04, v); chk({tag, " recv data"}, v, expd);
  endtask

  task automatic do_stop(input string tag);
    logic [7:0] v;
    wr(5'h08, cb | 8'h10); wait_idle(tag);
    repeat (50) @(negedge clk);
    rd(5'h08, v); chk({tag, " no flag after stop"}, v[3], 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (6) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    rd(5'h0C, v); chk("R1 reset status", v, 8'hF8);
    rd(5'h08, v); chk("R1 reset control", v, 8'h00);
    rd(5'h04, v); chk("R1 reset data", v, 8'h00);
    rd(5'h18, v); chk("R1 unmapped read", v, 8'h00);
    chk("R1 lines released", {scl_oe, sda_oe}, 0);
    wr(5'h00, 8'h2A); wr(5'h10, 8'h13);
    rd(5'h00, v); chk("R1 slave addr", v, 8'h2A);
    rd(5'h10, v); chk("R1 ext slave addr", v, 8'h13);
    wr(5'h0C, 8'h00);

    wr(5'h08, 8'h88);
    rd(5'h08, v); chk("R2 write-one to flag ignored", v, 8'h80);
    chk("R3 irq low without flag", irq, 0);

    wr(5'h08, 8'h20);
    repeat (300) @(negedge clk);
    rd(5'h0C, v); chk("R14 no start while disabled", v, 8'hF8);
    chk("R14 no start condition", n_start, 0);
    wr(5'h08, cb); wait_flag("R14");
    rd(5'h0C, v); chk("R4 start code", v, 8'h08);
    chk("R4 start condition seen", n_start, 1);
    chk("R3 irq with flag and enable", irq, 1);

    repeat (200) @(negedge clk);
    rd(5'h0C, v); chk("R9 code held", v, 8'h08);
    chk("R9 scl held low", scl_line, 0);

    do_send(8'hA0, 8'h18, "R6");
    chk("R6 address bits", last_addr, 8'hA0);
    do_send(8'h3C, 8'h28, "R7");
    do_send(8'hC3, 8'h28, "R7");
    chk("R7 first data byte", rx_log[0], 8'h3C);
    chk("R7 second data byte", rx_log[1], 8'hC3);

    do_start(8'h10, "R5");
    do_send(8'hA1, 8'h40, "R6");
    do_recv(1'b1, 8'hA5, 8'h50, "R8");
    do_recv(1'b1, 8'hB6, 8'h50, "R8");
    do_recv(1'b0, 8'hC7, 8'h58, "R8");
    do_stop("R10");
    rd(5'h0C, v); chk("R10 idle code", v, 8'hF8);
    chk("R10 irq low", irq, 0);
    chk("R13 start count", n_start, 2);
    chk("R13 stop count", n_stop, 1);

    do_start(8'h08, "R6"); do_send(8'hB0, 8'h20, "R6"); do_stop("R6");
    do_start(8'h08, "R6"); do_send(8'hB1, 8'h48, "R6"); do_stop("R6");

    nack_data = 1'b1;
    do_start(8'h08, "R7"); do_send(8'hA0, 8'h18, "R7"); do_send(8'h55, 8'h30, "R7");
    do_stop("R7");
    nack_data = 1'b0;
    chk("R7 nacked byte seen", rx_log[2], 8'h55);

    cb = 8'h40;
    do_start(8'h08, "R3");
    rd(5'h08, v); chk("R3 flag set", v, 8'h48);
    chk("R3 irq masked", irq, 0);
    do_stop("R3");
    cb = 8'hC0;
    chk("R13 edge totals start", n_start, 6);
    chk("R13 edge totals stop", n_stop, 5);

    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 3; n++) begin
        wr(5'h0C, 8'((m << 3) | n));
        do_start(8'h08, "R11");
        do_send(8'hA0, 8'h18, "R11");
        chk("R11 scl period", rise_period, 10 * (m + 1) * (2 << n));
        do_stop("R11");
      end
    end

    do_start(8'h08, "R12");
    wr(5'h1C, 8'h00);
    rd(5'h0C, v); chk("R12 status after soft reset", v, 8'hF8);
    rd(5'h08, v); chk("R12 control after soft reset", v, 8'h00);
    rd(5'h00, v); chk("R12 slave addr restored", v, 8'h00);
    rd(5'h10, v); chk("R12 ext addr restored", v, 8'h00);
    chk("R12 lines released", {scl_oe, sda_oe, irq}, 0);
    do_start(8'h08, "R12");
    do_send(8'hA0, 8'h18, "R12");
    chk("R11 reset baud period", rise_period, 2880);
    do_stop("R12");

    finish_run();
  end
endmodule